// File: doc/BRIEF.md
# Embedded Controller Host Command Port

This block is the device side of a byte-wide host port into an embedded controller. The host sees two locations. One is a data buffer. The other returns a status byte when read and accepts a command byte when written. Behind the port, a sequencer interprets the command stream and performs reads and writes on an internal byte-addressed register space. That space is reached through a simple address, write-data, write-enable and read-data interface.

Traffic through the port is handshaked by two flags. The input-full flag rises on every host write and stays up until the sequencer has consumed the byte, which takes a fixed, parameterised number of cycles. The output-full flag rises when the controller leaves a byte for the host and drops when the host reads it. A read is a command byte followed by an address byte. A write is a command byte, an address byte and a data byte. Burst on, burst off and a query command complete on their own command byte.

Top module: `ec_host_port`

## Requirements
- R1: With `host_sel` low the port addresses the data buffer; with `host_sel` high a read returns status and a write delivers a command. Status bits: bit 0 output-full, bit 1 input-full, bit 3 last input byte was a command, bit 4 burst active; all other bits read 0.
- R2: After reset the status byte and the data buffer both read 0x00 and `reg_we` is low.
- R3: Every host write sets input-full in the following cycle, and input-full stays set for exactly `IBF_LAT` cycles. A write that lands while input-full is still set replaces the pending byte and restarts the count; the replaced byte is never acted on.
- R4: A host read of the data buffer returns the buffered byte and clears output-full after that cycle; status reads leave output-full unchanged.
- R5: Status bit 3 reads 1 after a byte was written with `host_sel` high and 0 after a byte was written with `host_sel` low.
- R6: Command 0x80 followed by an address byte loads the register-space value at that address into the data buffer and sets output-full.
- R7: Command 0x81 followed by an address byte and a data byte produces exactly one `reg_we` pulse carrying that address and data.
- R8: Command 0x82 sets the burst bit and places 0x90 in the data buffer with output-full; command 0x83 clears the burst bit and leaves output-full unchanged.
- R9: Command 0x84 places 0x00 in the data buffer and sets output-full.
- R10: A command byte that arrives in the middle of a read or write sequence abandons that sequence and starts the new command; the abandoned write never pulses `reg_we`.
- R11: A data byte outside any sequence, and a command byte with an unlisted code, cause no register write and no output-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip select |
| host_sel | input | 1 | 0: data buffer, 1: status / command |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte returned to the host |
| reg_addr | output | 8 | Register-space address |
| reg_wdata | output | 8 | Register-space write data |
| reg_we | output | 1 | Register-space write enable, one-cycle pulse |
| reg_rdata | input | 8 | Register-space read data for `reg_addr` |

## Verification
The bench sweeps every one of the 256 register addresses, first with full write sequences and then with read sequences. It compares each value read back against an arithmetic pattern, so an address or data byte taken in the wrong order surfaces as a mismatch. It counts input-full cycle by cycle after a write, which catches a latency that is off by one. A command overwritten before it is taken must leave no trace, and a design that lets the stale byte run would start an unwanted read. The bench also breaks a write sequence with a new read command: a design that finished the old sequence would pulse the write enable, and one that dropped the new command would never raise output-full. Stray data bytes and unknown codes must change neither the register space nor the flags.

// File: rtl/ec_pkg.sv
package ec_pkg;
    localparam logic [7:0] CMD_READ     = 8'h80;
    localparam logic [7:0] CMD_WRITE    = 8'h81;
    localparam logic [7:0] CMD_BURST_ON = 8'h82;
    localparam logic [7:0] CMD_BURST_OF = 8'h83;
    localparam logic [7:0] CMD_QUERY    = 8'h84;
    localparam logic [7:0] BURST_ACK    = 8'h90;
    localparam logic [7:0] QUERY_NONE   = 8'h00;

    localparam int SB_OBF   = 0;
    localparam int SB_IBF   = 1;
    localparam int SB_CMD   = 3;
    localparam int SB_BURST = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RADDR,
        SQ_RCAP,
        SQ_WADDR,
        SQ_WDATA
    } sq_state_e;
endpackage

// File: rtl/ec_ibf_timer.sv
module ec_ibf_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic take
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (load)
            d.cnt = CW'(LAT);
        else if (q.cnt != '0)
            d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.cnt != '0);
    assign take = (q.cnt == CW'(1)) && !load;

    assert_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !busy);
    assert_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
    import ec_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] byte_in,
    input  logic          is_cmd,
    input  logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          burst,
    output logic          ld_valid,
    output logic [DW-1:0] ld_byte
);
    typedef struct packed {
        sq_state_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          we;
        logic          burst;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        ld_valid = 1'b0;
        ld_byte  = '0;
        if (q.st == SQ_RCAP) begin
            ld_valid = 1'b1;
            ld_byte  = reg_rdata;
            d.st     = SQ_IDLE;
        end
        if (take) begin
            if (is_cmd) begin
                d.st = SQ_IDLE;
                case (byte_in)
                    CMD_READ:     d.st = SQ_RADDR;
                    CMD_WRITE:    d.st = SQ_WADDR;
                    CMD_BURST_ON: begin
                        d.burst  = 1'b1;
                        ld_valid = 1'b1;
                        ld_byte  = DW'(BURST_ACK);
                    end
                    CMD_BURST_OF: d.burst = 1'b0;
                    CMD_QUERY: begin
                        ld_valid = 1'b1;
                        ld_byte  = DW'(QUERY_NONE);
                    end
                    default: ;
                endcase
            end else begin
                case (q.st)
                    SQ_RADDR: begin
                        d.addr = AW'(byte_in);
                        d.st   = SQ_RCAP;
                    end
                    SQ_WADDR: begin
                        d.addr = AW'(byte_in);
                        d.st   = SQ_WDATA;
                    end
                    SQ_WDATA: begin
                        d.wdata = byte_in;
                        d.we    = 1'b1;
                        d.st    = SQ_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_IDLE, addr: '0, wdata: '0, we: 1'b0, burst: 1'b0};
        else        q <= d;
    end

    assign reg_addr  = q.addr;
    assign reg_wdata = q.wdata;
    assign reg_we    = q.we;
    assign burst     = q.burst;

    assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_abort_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_cmd) |=> !reg_we);
    assert_idle_data_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_cmd && q.st == SQ_IDLE) |=> (!reg_we && !ld_valid));
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_pkg::*;
#(
    parameter int IBF_LAT = 4,
    parameter int AW      = 8,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs,
    input  logic          host_sel,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    input  logic [DW-1:0] reg_rdata
);
    typedef struct packed {
        logic [DW-1:0] ibuf;
        logic          cmdf;
        logic [DW-1:0] obuf;
        logic          obf;
    } port_t;

    port_t q, d;

    logic          wr_hit, rd_data_hit;
    logic          ibf, take, burst, ld_valid;
    logic [DW-1:0] ld_byte;
    logic [7:0]    status;

    assign wr_hit      = host_cs && host_wr;
    assign rd_data_hit = host_cs && host_rd && !host_sel;

    ec_ibf_timer #(.LAT(IBF_LAT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_hit),
        .busy  (ibf),
        .take  (take)
    );

    ec_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .byte_in   (q.ibuf),
        .is_cmd    (q.cmdf),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .burst     (burst),
        .ld_valid  (ld_valid),
        .ld_byte   (ld_byte)
    );

    always_comb begin
        d = q;
        if (wr_hit) begin
            d.ibuf = DW'(host_wdata);
            d.cmdf = host_sel;
        end
        if (rd_data_hit)
            d.obf = 1'b0;
        if (ld_valid) begin
            d.obuf = ld_byte;
            d.obf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status           = '0;
        status[SB_OBF]   = q.obf;
        status[SB_IBF]   = ibf;
        status[SB_CMD]   = q.cmdf;
        status[SB_BURST] = burst;
    end

    assign host_rdata = host_sel ? status : 8'(q.obuf);

    assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> status[SB_IBF]);
    assert_obf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_hit && !ld_valid) |=> !q.obf);
    assert_obf_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> q.obf);
    assert_cmd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (status[SB_CMD] == $past(host_sel)));
endmodule

// File: tb/tb_ec_host_port.sv
module tb_ec_host_port;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;

    logic [7:0] mem [256];
    int         we_cnt = 0;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    ec_host_port #(.IBF_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_sel(host_sel),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic sel, input logic [7:0] b);
        host_cs = 1'b1; host_wr = 1'b1; host_sel = sel; host_wdata = b;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hread(input logic sel, output logic [7:0] b);
        host_cs = 1'b1; host_rd = 1'b1; host_sel = sel;
        #1 b = host_rdata;
        @(negedge clk);
        host_cs = 1'b0; host_rd = 1'b0;
    endtask

    task automatic wait_ibf(input string req);
        logic [7:0] s;
        int n = 0;
        hread(1'b1, s);
        while (s[1] && n < 100) begin hread(1'b1, s); n++; end
        if (n >= 100) chk(req, s, s & 8'hFD);
    endtask

    task automatic wait_obf(input string req);
        logic [7:0] s;
        int n = 0;
        hread(1'b1, s);
        while (!s[0] && n < 100) begin hread(1'b1, s); n++; end
        if (n >= 100) chk(req, s, s | 8'h01);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] v);
        wait_ibf("R7"); hwrite(1'b1, 8'h81);
        wait_ibf("R7"); hwrite(1'b0, a);
        wait_ibf("R7"); hwrite(1'b0, v);
        wait_ibf("R7"); @(negedge clk); @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] v);
        wait_ibf("R6"); hwrite(1'b1, 8'h80);
        wait_ibf("R6"); hwrite(1'b0, a);
        wait_obf("R6"); hread(1'b0, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] s, v;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        hread(1'b1, s); chk("R2 status", s, 8'h00);
        hread(1'b0, v); chk("R2 data", v, 8'h00);
        chk("R2 we", {7'b0, reg_we}, 8'h00);

        // R3 exact latency, R5 command flag
        hwrite(1'b1, 8'h83);
        for (int i = 1; i <= LAT; i++) begin
            hread(1'b1, s); chk("R3 ibf high", {7'b0, s[1]}, 8'h01);
            if (i == 1) chk("R5 cmd flag set", {7'b0, s[3]}, 8'h01);
        end
        hread(1'b1, s); chk("R3 ibf low", {7'b0, s[1]}, 8'h00);
        hwrite(1'b0, 8'h33);
        hread(1'b1, s); chk("R5 cmd flag clear", {7'b0, s[3]}, 8'h00);
        wait_ibf("R11"); repeat (3) @(negedge clk);
        hread(1'b1, s); chk("R11 stray data no obf", {7'b0, s[0]}, 8'h00);
        chk("R11 stray data no write", 8'(we_cnt), 8'h00);

        // R3 overwrite: pending read command replaced by query
        hwrite(1'b1, 8'h80);
        @(negedge clk);
        hwrite(1'b1, 8'h84);
        for (int i = 1; i <= LAT; i++) begin
            hread(1'b1, s); chk("R3 restart ibf high", {7'b0, s[1]}, 8'h01);
        end
        wait_obf("R9");
        hread(1'b1, s); chk("R4 status keeps obf", {7'b0, s[0]}, 8'h01);
        hread(1'b0, v); chk("R9 query value", v, 8'h00);
        hread(1'b1, s); chk("R4 obf cleared", {7'b0, s[0]}, 8'h00);
        hwrite(1'b0, 8'h10);
        wait_ibf("R3"); repeat (3) @(negedge clk);
        hread(1'b1, s); chk("R3 replaced read never ran", {7'b0, s[0]}, 8'h00);

        // R8 burst on/off, R1 status layout
        wait_ibf("R8"); hwrite(1'b1, 8'h82);
        wait_obf("R8");
        hread(1'b1, s); chk("R1 R8 status burst", s, 8'h19);
        hread(1'b0, v); chk("R8 ack", v, 8'h90);
        hwrite(1'b1, 8'h83);
        wait_ibf("R8"); repeat (2) @(negedge clk);
        hread(1'b1, s); chk("R8 burst off", s, 8'h08);

        // R11 unknown code followed by data
        hwrite(1'b1, 8'h85); wait_ibf("R11");
        hwrite(1'b0, 8'h22); wait_ibf("R11"); repeat (3) @(negedge clk);
        hread(1'b1, s); chk("R11 unknown code", {7'b0, s[0]}, 8'h00);
        chk("R11 unknown no write", 8'(we_cnt), 8'h00);

        // R10 abort a write with a read
        hwrite(1'b1, 8'h81); wait_ibf("R10");
        hwrite(1'b0, 8'h10); wait_ibf("R10");
        hwrite(1'b1, 8'h80); wait_ibf("R10");
        hwrite(1'b0, 8'h20);
        wait_obf("R10");
        hread(1'b0, v); chk("R10 new read value", v, 8'h20 ^ 8'h5A);
        chk("R10 no write", 8'(we_cnt), 8'h00);

        // R6 initial contents on a few addresses
        for (int a = 0; a < 256; a += 51) begin
            do_read(8'(a), v); chk("R6 initial read", v, 8'(a) ^ 8'h5A);
        end

        // R7 write sweep, R6 read sweep
        for (int a = 0; a < 256; a++) begin
            w0 = we_cnt;
            do_write(8'(a), pat(a));
            chk("R7 one pulse", 8'(we_cnt - w0), 8'h01);
        end
        for (int a = 0; a < 256; a++) begin
            do_read(8'(a), v); chk("R6 R7 readback", v, pat(a));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule